// File: doc/BRIEF.md
# USB IN Endpoint Interrupt Logic

This block produces the interrupt status, the interrupt mask and a single interrupt request for the IN direction of a USB control endpoint. The endpoint engine reports events to it as single-cycle strobes. These are a successful IN transmission with its byte count, a STALL returned to the host, a SETUP packet received and a bus reset. The engine also supplies the current IN FIFO fill level and the configured maximum packet size. The block turns these into sticky status bits. Software reads the bits and clears them over a simple synchronous register bus.

Two of the sources need history. End-of-transfer must remember whether the previous packet was full size. The first zero-length packet after full-size packets ends a transfer, but a further zero-length packet does not. The halt and unhalt events are edges of an internal halt state, not raw strobes. The FIFO level event fires once, when the level falls through a software-programmed threshold.

Top module: `usb_in_irq`

## Requirements
- R1: Register offsets are: 0 for status (write-1-to-clear), 1 for mask (read/write) and 2 for the FIFO threshold (read/write). Status and mask use bit 4 for halt, bit 3 for unhalt, bit 2 for end-of-packet, bit 1 for end-of-transfer and bit 0 for FIFO level. Reads return the addressed register zero-extended, in the same cycle. After reset all three registers read zero.
- R2: Every cycle with a successful IN transmission strobe sets the end-of-packet bit.
- R3: A transmission whose length is nonzero and less than the maximum packet size sets the end-of-transfer bit.
- R4: A zero-length transmission sets end-of-transfer only when the previous transmission was full size (length at or above the maximum). Full-size transmissions never set it. A second zero-length packet in a row does not set it.
- R5: A SETUP packet or a bus reset forgets the full-size history, so a later zero-length packet does not set end-of-transfer.
- R6: A STALL strobe puts the endpoint in the halted state and sets the halt bit only if the endpoint was not already halted. A STALL in the same cycle as a SETUP or bus reset is overridden and sets nothing.
- R7: A SETUP packet or a bus reset while halted leaves the halted state and sets the unhalt bit. The same strobes while not halted set nothing.
- R8: The FIFO level bit sets only in the cycle the fill level goes from at-or-above the threshold to below it. It is not set again while the level stays below.
- R9: Status bits are sticky. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the bit set.
- R10: The interrupt request is high exactly when some status bit is 1 and its mask bit is 1. The mask resets to zero, so nothing is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pkt_sent | input | 1 | IN packet transmitted successfully (strobe) |
| ev_pkt_len | input | LEN_W | Byte count of that packet |
| max_pkt | input | LEN_W | Configured maximum packet size |
| ev_stall | input | 1 | STALL returned to host (strobe) |
| ev_setup | input | 1 | SETUP packet received (strobe) |
| ev_bus_reset | input | 1 | USB bus reset seen (strobe) |
| fifo_level | input | LVL_W | Current IN FIFO fill level |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench attacks the end-of-transfer history with these sequences:
- full then zero-length: a design without history never flags it;
- zero-length twice: a design that ignores the "first only" rule flags both;
- full, SETUP or bus reset, then zero-length: a design whose history is not cleared flags it wrongly.

It repeats STALL while halted and checks that the halt bit stays clear after software cleared it, which catches a design that passes the raw strobe through. It also drives STALL together with SETUP, where the clear must win. It holds the FIFO level below threshold after a clear; a level-sensitive design would set the bit again. It issues a write-one clear in the same cycle as a new event; a design that gives the clear priority loses that event.

// File: rtl/usb_in_irq_pkg.sv
`timescale 1ns/1ps
package usb_in_irq_pkg;
    localparam int NUM_SRC    = 5;
    localparam int IDX_LVL    = 0;
    localparam int IDX_EOT    = 1;
    localparam int IDX_EOP    = 2;
    localparam int IDX_UNHALT = 3;
    localparam int IDX_HALT   = 4;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_MASK   = 2'd1;
    localparam logic [1:0] ADDR_THRESH = 2'd2;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/usb_in_eot_track.sv
`timescale 1ns/1ps
module usb_in_eot_track #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_sent,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic             restart,
    output logic             eot_hit
);
    typedef struct packed {
        logic prev_full;
    } eot_state_t;

    eot_state_t st_d, st_q;
    logic is_full, is_zlp;

    always_comb begin
        st_d    = st_q;
        is_full = (pkt_len >= max_len);
        is_zlp  = (pkt_len == '0);
        eot_hit = 1'b0;
        if (pkt_sent) begin
            if (is_zlp) eot_hit = st_q.prev_full;
            else        eot_hit = !is_full;
            st_d.prev_full = is_full;
        end
        if (restart) st_d.prev_full = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/usb_in_halt_track.sv
`timescale 1ns/1ps
module usb_in_halt_track (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic unstall,
    output logic halt_set,
    output logic halt_clr
);
    typedef struct packed {
        logic halted;
    } halt_state_t;

    halt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        halt_set = 1'b0;
        halt_clr = 1'b0;
        if (st_q.halted) begin
            if (unstall) begin
                st_d.halted = 1'b0;
                halt_clr    = 1'b1;
            end
        end else if (stall && !unstall) begin
            st_d.halted = 1'b1;
            halt_set    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/usb_in_level_cross.sv
`timescale 1ns/1ps
module usb_in_level_cross #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             fell_below
);
    typedef struct packed {
        logic above;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d.above = (level >= thresh);
        fell_below = st_q.above && !st_d.above;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/usb_in_irq.sv
`timescale 1ns/1ps
module usb_in_irq
    import usb_in_irq_pkg::*;
#(
    parameter int LEN_W  = 10,
    parameter int LVL_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_pkt_sent,
    input  logic [LEN_W-1:0]  ev_pkt_len,
    input  logic [LEN_W-1:0]  max_pkt,
    input  logic              ev_stall,
    input  logic              ev_setup,
    input  logic              ev_bus_reset,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int PAD_SRC = DATA_W - NUM_SRC;
    localparam int PAD_LVL = DATA_W - LVL_W;

    typedef struct packed {
        src_vec_t         status;
        src_vec_t         mask;
        logic [LVL_W-1:0] thresh;
    } regs_t;

    regs_t regs_d, regs_q;

    logic     restart;
    logic     eot_hit, halt_set, halt_clr, lvl_fell;
    src_vec_t set_vec, clr_vec;
    logic     wr_status, wr_mask, wr_thresh;
    src_vec_t sts_w, msk_w;

    assign restart = ev_setup | ev_bus_reset;

    usb_in_eot_track #(.LEN_W(LEN_W)) u_eot (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_sent (ev_pkt_sent),
        .pkt_len  (ev_pkt_len),
        .max_len  (max_pkt),
        .restart  (restart),
        .eot_hit  (eot_hit)
    );

    usb_in_halt_track u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (ev_stall),
        .unstall  (restart),
        .halt_set (halt_set),
        .halt_clr (halt_clr)
    );

    usb_in_level_cross #(.LVL_W(LVL_W)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (fifo_level),
        .thresh     (regs_q.thresh),
        .fell_below (lvl_fell)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[IDX_HALT]   = halt_set;
        set_vec[IDX_UNHALT] = halt_clr;
        set_vec[IDX_EOP]    = ev_pkt_sent;
        set_vec[IDX_EOT]    = eot_hit;
        set_vec[IDX_LVL]    = lvl_fell;

        wr_status = bus_sel && bus_we && (bus_addr == ADDR_STATUS);
        wr_mask   = bus_sel && bus_we && (bus_addr == ADDR_MASK);
        wr_thresh = bus_sel && bus_we && (bus_addr == ADDR_THRESH);
        clr_vec   = wr_status ? bus_wdata[NUM_SRC-1:0] : '0;

        regs_d = regs_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            regs_d.status[i] = set_vec[i] | (regs_q.status[i] & ~clr_vec[i]);
        end
        if (wr_mask)   regs_d.mask   = bus_wdata[NUM_SRC-1:0];
        if (wr_thresh) regs_d.thresh = bus_wdata[LVL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_STATUS: bus_rdata = {{PAD_SRC{1'b0}}, regs_q.status};
            ADDR_MASK:   bus_rdata = {{PAD_SRC{1'b0}}, regs_q.mask};
            ADDR_THRESH: bus_rdata = {{PAD_LVL{1'b0}}, regs_q.thresh};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq   = |(regs_q.status & regs_q.mask);
    assign sts_w = regs_q.status;
    assign msk_w = regs_q.mask;
endmodule

module usb_in_irq_chk
    import usb_in_irq_pkg::*;
#(
    parameter int LEN_W  = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_pkt_sent,
    input logic [LEN_W-1:0]  ev_pkt_len,
    input logic [LEN_W-1:0]  max_pkt,
    input logic              ev_setup,
    input logic              ev_bus_reset,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input src_vec_t          status,
    input src_vec_t          mask,
    input logic              irq
);
    src_vec_t keep_vec;
    always_comb begin
        keep_vec = status;
        if (bus_sel && bus_we && bus_addr == ADDR_STATUS)
            keep_vec = status & ~bus_wdata[NUM_SRC-1:0];
    end

    a_r2_eop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_sent |=> status[IDX_EOP]);

    a_r3_short_sets_eot: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pkt_sent && ev_pkt_len != '0 && ev_pkt_len < max_pkt) |=> status[IDX_EOT]);

    a_r7_unhalt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[IDX_UNHALT]) |-> $past(ev_setup || ev_bus_reset));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(keep_vec)) == $past(keep_vec)));

    a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0) && (status != '0));
endmodule

bind usb_in_irq usb_in_irq_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_pkt_sent  (ev_pkt_sent),
    .ev_pkt_len   (ev_pkt_len),
    .max_pkt      (max_pkt),
    .ev_setup     (ev_setup),
    .ev_bus_reset (ev_bus_reset),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .status       (sts_w),
    .mask         (msk_w),
    .irq          (irq)
);

// File: tb/usb_in_irq_test.sv
`timescale 1ns/1ps
module usb_in_irq_test;
    localparam int LEN_W  = 10;
    localparam int LVL_W  = 7;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_pkt_sent = 1'b0;
    logic [LEN_W-1:0]  ev_pkt_len = '0;
    logic [LEN_W-1:0]  max_pkt = LEN_W'(64);
    logic              ev_stall = 1'b0;
    logic              ev_setup = 1'b0;
    logic              ev_bus_reset = 1'b0;
    logic [LVL_W-1:0]  fifo_level = LVL_W'(20);
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_addr = 2'd0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [DATA_W:0] exp_q[$];
    string           tag_q[$];

    always #2.5 clk = ~clk;

    usb_in_irq #(.LEN_W(LEN_W), .LVL_W(LVL_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .ev_pkt_sent(ev_pkt_sent), .ev_pkt_len(ev_pkt_len),
        .max_pkt(max_pkt), .ev_stall(ev_stall), .ev_setup(ev_setup),
        .ev_bus_reset(ev_bus_reset), .fifo_level(fifo_level), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: pops the expected item for every read cycle.
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_we) begin
            logic [DATA_W:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expectation, actual %h", {irq, bus_rdata});
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({irq, bus_rdata} !== e) begin
                    errors++;
                    $display("FAIL %s: addr %0d actual irq=%b data=%h expected irq=%b data=%h",
                             t, bus_addr, irq, bus_rdata, e[DATA_W], e[DATA_W-1:0]);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [DATA_W-1:0] d,
                             input logic ir, input string t);
        exp_q.push_back({ir, d});
        tag_q.push_back(t);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic pkt(input int len);
        ev_pkt_sent = 1'b1; ev_pkt_len = LEN_W'(len);
        tick();
        ev_pkt_sent = 1'b0;
    endtask

    task automatic strobe(input logic s, input logic su, input logic br);
        ev_stall = s; ev_setup = su; ev_bus_reset = br;
        tick();
        ev_stall = 1'b0; ev_setup = 1'b0; ev_bus_reset = 1'b0;
    endtask

    task automatic clear_all();
        wr(2'd0, 8'h1F);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        expect_rd(2'd0, 8'h00, 1'b0, "R1 status reset");
        expect_rd(2'd1, 8'h00, 1'b0, "R1 mask reset");
        expect_rd(2'd2, 8'h00, 1'b0, "R1 threshold reset");

        // R2 / R4: full-size packet sets only end-of-packet
        pkt(64);
        expect_rd(2'd0, 8'h04, 1'b0, "R2 R4 full packet");
        clear_all();
        pkt(0);
        expect_rd(2'd0, 8'h06, 1'b0, "R4 first zlp after full");
        clear_all();
        pkt(0);
        expect_rd(2'd0, 8'h04, 1'b0, "R4 second zlp");
        clear_all();
        // R3 short packet
        pkt(10);
        expect_rd(2'd0, 8'h06, 1'b0, "R3 short packet");
        clear_all();
        // R5 history cleared by SETUP and bus reset
        pkt(64); strobe(1'b0, 1'b1, 1'b0); pkt(0);
        expect_rd(2'd0, 8'h04, 1'b0, "R5 R7 setup clears history, no unhalt");
        clear_all();
        pkt(64); strobe(1'b0, 1'b0, 1'b1); pkt(0);
        expect_rd(2'd0, 8'h04, 1'b0, "R5 bus reset clears history");
        clear_all();

        // R6 / R7 halt tracking
        strobe(1'b1, 1'b0, 1'b0);
        expect_rd(2'd0, 8'h10, 1'b0, "R6 stall sets halt");
        clear_all();
        strobe(1'b1, 1'b0, 1'b0);
        expect_rd(2'd0, 8'h00, 1'b0, "R6 stall while halted");
        strobe(1'b0, 1'b1, 1'b0);
        expect_rd(2'd0, 8'h08, 1'b0, "R7 setup unhalts");
        clear_all();
        strobe(1'b0, 1'b1, 1'b0);
        expect_rd(2'd0, 8'h00, 1'b0, "R7 setup while not halted");
        strobe(1'b1, 1'b1, 1'b0);
        expect_rd(2'd0, 8'h00, 1'b0, "R6 stall with setup overridden");
        strobe(1'b0, 1'b1, 1'b0);
        expect_rd(2'd0, 8'h00, 1'b0, "R6 still not halted");
        strobe(1'b1, 1'b0, 1'b0);
        clear_all();
        strobe(1'b0, 1'b0, 1'b1);
        expect_rd(2'd0, 8'h08, 1'b0, "R7 bus reset unhalts");
        clear_all();

        // R9 write-one-to-clear
        strobe(1'b1, 1'b0, 1'b0);
        pkt(64);
        expect_rd(2'd0, 8'h14, 1'b0, "R9 two bits set");
        wr(2'd0, 8'h00);
        expect_rd(2'd0, 8'h14, 1'b0, "R9 write zero no effect");
        wr(2'd0, 8'h04);
        expect_rd(2'd0, 8'h10, 1'b0, "R9 single bit cleared");
        ev_pkt_sent = 1'b1; ev_pkt_len = LEN_W'(64);
        wr(2'd0, 8'h04);
        ev_pkt_sent = 1'b0;
        expect_rd(2'd0, 8'h14, 1'b0, "R9 event beats clear");
        clear_all();
        expect_rd(2'd0, 8'h00, 1'b0, "R9 all cleared");
        strobe(1'b0, 1'b1, 1'b0);
        clear_all();

        // R10 mask and request
        pkt(10);
        expect_rd(2'd0, 8'h06, 1'b0, "R10 mask zero blocks");
        wr(2'd1, 8'h02);
        expect_rd(2'd1, 8'h02, 1'b1, "R10 enabled eot raises irq");
        wr(2'd1, 8'h19);
        expect_rd(2'd0, 8'h06, 1'b0, "R10 other bits enabled only");
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h04);
        expect_rd(2'd0, 8'h04, 1'b1, "R10 eop enabled");
        clear_all();
        expect_rd(2'd0, 8'h00, 1'b0, "R10 irq drops after clear");
        wr(2'd1, 8'h00);

        // R8 level crossing
        wr(2'd2, 8'd8);
        expect_rd(2'd2, 8'd8, 1'b0, "R1 threshold readback");
        fifo_level = LVL_W'(5);
        tick();
        expect_rd(2'd0, 8'h01, 1'b0, "R8 level falls below");
        clear_all();
        repeat (3) tick();
        expect_rd(2'd0, 8'h00, 1'b0, "R8 no re-set while below");
        fifo_level = LVL_W'(9);
        tick();
        fifo_level = LVL_W'(8);
        tick();
        expect_rd(2'd0, 8'h00, 1'b0, "R8 at threshold is not below");
        fifo_level = LVL_W'(7);
        tick();
        expect_rd(2'd0, 8'h01, 1'b0, "R8 second crossing");
        clear_all();

        tick();
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule